// File: doc/BRIEF.md
# SMBus Alert Responder

This block is the interrupt side of an SMBus slave. An event on `fault_evt_i` sets a sticky interrupt latch, and the latch holds the shared active-low ALERT wire down through an open-drain pull enable. The host finds out who raised the interrupt by sending the alert response address with the read bit set. Every device whose latch is set acknowledges that byte and then shifts out its own 7-bit address. Because the data wire is wired-AND, the lowest address wins bit by bit.

The winner drops its latch at the end of the returned byte. A device that loses stops driving at once and keeps ALERT low, so a later service cycle can pick it up.

SMBCLK and SMBDATA are oversampled on the system clock. The block never stretches the clock. It only pulls SMBDATA low, for its acknowledge and for the 0 bits of the byte it returns.

Top module: `smb_alert_responder`

## Requirements
- R1: A single-cycle high on `fault_evt_i` sets the interrupt latch. From the next clock on, `alert_drive_o` and `irq_pending_o` are 1, and they stay 1 after the fault input returns low.
- R2: After reset the latch is clear and `alert_drive_o`, `irq_pending_o` and `sda_drive_low_o` are all 0.
- R3: With the latch set, a first byte of 0x19 after a START is acknowledged. That byte is address 0b0001100 sent MSB first, followed by read bit 1. The acknowledge is SDA held low during the ninth SCL high phase.
- R4: After acknowledging, the block returns one byte, MSB first: `dev_addr_i[6:0]` followed by a final 1. Each bit changes only while SCL is low, and the line level is constant throughout each SCL high phase.
- R5: When the block has placed its whole byte without losing arbitration, the host's acknowledge bit clears the latch, whether the host sends ACK (0) or NACK (1). `alert_drive_o` and `irq_pending_o` then return to 0.
- R6: If the block releases SDA for a 1 but samples 0 during SCL high, it has lost arbitration. It drives nothing more in that transaction and its latch stays set.
- R7: With the latch clear, the block does not acknowledge 0x19 and never drives SDA low.
- R8: Any first byte other than 0x19 (a write to the alert address, or a read of another address) gets no acknowledge and no SDA drive, and leaves the latch unchanged.
- R9: A fault event in the same cycle as the clearing acknowledge wins, and the latch stays set.
- R10: A STOP in the middle of a transaction aborts it and leaves the latch unchanged. A START in the middle of a transaction abandons it and begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBCLK level seen on the wire |
| sda_i | input | 1 | SMBDATA level seen on the wire |
| fault_evt_i | input | 1 | Fault event, sets the interrupt latch |
| dev_addr_i | input | 7 | This device's fixed 7-bit address |
| sda_drive_low_o | output | 1 | 1 pulls SMBDATA low (open-drain enable) |
| alert_drive_o | output | 1 | 1 pulls the ALERT wire low |
| irq_pending_o | output | 1 | Interrupt latch state |

## Verification
The alert address is sent three ways: with the latch clear, with the latch set, and next to near-miss bytes. The near misses are the same address with the write bit and a read of a different address. Together these separate address decoding from latch gating.

Service cycles run in three settings: alone, against a modelled rival with a lower address that overrides one of the block's 1 bits, and with a fault held across the host's acknowledge. These show the difference between a win, a loss with silent drop-out, and set-over-clear priority.

Bytes cut short by a STOP, and by a repeated START, confirm that an abort leaves the latch alone and that the block can restart.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ALERT_RESP_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKWAIT,
    ST_ACK,
    ST_SEND,
    ST_HACK,
    ST_SKIP
  } ara_state_e;
endpackage

// File: rtl/smb_line_monitor.sv
module smb_line_monitor #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_now;

  assign scl_now = scl_sync[LAST];
  assign sda_lvl = sda_sync[LAST];

  // idle bus reads high, so the stages reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_now;
      sda_q    <= sda_lvl;
    end
  end

  assign scl_rise  =  scl_now & ~scl_q;
  assign scl_fall  = ~scl_now &  scl_q;
  assign start_det =  scl_now &  scl_q &  sda_q & ~sda_lvl;
  assign stop_det  =  scl_now &  scl_q & ~sda_q &  sda_lvl;
endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
  import smb_alert_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              irq_set,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_pull,
  output logic              clr_req,
  output logic              arb_lost
);
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_READ = {ALERT_RESP_ADDR, 1'b1};

  ara_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic              lost_q, lost_d;
  logic [BYTE_W-1:0] rx_shift;

  assign rx_shift = {rx_q[BYTE_W-2:0], sda_lvl};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    lost_d  = lost_q;
    clr_req = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      lost_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          rx_d = rx_shift;
          if (cnt_q == CNT_LAST) begin
            cnt_d   = '0;
            state_d = (rx_shift == ARA_READ && irq_set) ? ST_ACKWAIT : ST_SKIP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ACKWAIT: if (scl_fall) state_d = ST_ACK;
        ST_ACK: if (scl_fall) begin
          state_d = ST_SEND;
          cnt_d   = '0;
          tx_d    = {dev_addr, 1'b1};
          lost_d  = 1'b0;
        end
        ST_SEND: begin
          if (scl_rise && tx_q[BYTE_W-1] && !sda_lvl) lost_d = 1'b1;
          if (scl_fall) begin
            tx_d = {tx_q[BYTE_W-2:0], 1'b1};
            if (cnt_q == CNT_LAST) state_d = ST_HACK;
            else cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HACK: if (scl_rise) begin
          clr_req = ~lost_q;
          state_d = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      lost_q  <= lost_d;
    end
  end

  assign sda_pull = (state_q == ST_ACK) |
                    ((state_q == ST_SEND) & ~tx_q[BYTE_W-1] & ~lost_q);
  assign arb_lost = lost_q;
endmodule

// File: rtl/smb_irq_latch.sv
module smb_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic pending
);
  logic pend_q, pend_en, pend_d;

  // a set in the clearing cycle wins
  always_comb begin
    pend_en = set_evt | clr_req;
    pend_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
  import smb_alert_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              fault_evt_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_drive_low_o,
  output logic              alert_drive_o,
  output logic              irq_pending_o
);
  logic [1:0] rst_pipe;
  logic rst_sync_n;
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic clr_pulse, arb_lost, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  smb_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_ara_fsm i_fsm (
    .clk(clk), .rst_n(rst_sync_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .irq_set(pending), .dev_addr(dev_addr_i),
    .sda_pull(sda_drive_low_o), .clr_req(clr_pulse), .arb_lost(arb_lost)
  );

  smb_irq_latch i_latch (
    .clk(clk), .rst_n(rst_sync_n), .set_evt(fault_evt_i),
    .clr_req(clr_pulse), .pending(pending)
  );

  assign alert_drive_o = pending;
  assign irq_pending_o = pending;
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic fault_evt_i,
  input logic irq_pending_o,
  input logic sda_drive_low_o,
  input logic clr_pulse,
  input logic arb_lost
);
  a_r1_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt_i |=> irq_pending_o);
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !fault_evt_i) |=> !irq_pending_o);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && fault_evt_i) |=> irq_pending_o);
  a_r6_loser_silent: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !sda_drive_low_o);
  a_r7_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending_o |-> !sda_drive_low_o);
endmodule

bind smb_alert_responder smb_alert_responder_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .fault_evt_i(fault_evt_i),
  .irq_pending_o(irq_pending_o), .sda_drive_low_o(sda_drive_low_o),
  .clr_pulse(clr_pulse), .arb_lost(arb_lost)
);

// File: tb/test_smb_alert_responder.sv
`timescale 1ns/1ps
module test_smb_alert_responder;
  localparam int HALF = 10;
  localparam logic [6:0] DEV   = 7'h52;
  localparam logic [6:0] RIVAL = 7'h4A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_q = 1'b1, host_sda = 1'b1, rival_rel = 1'b1, fault = 1'b0;
  logic sda_drv, alert, pend;
  wire  sda_bus = host_sda & rival_rel & ~sda_drv;
  int   n_chk = 0, n_bad = 0, drive_cnt = 0, cyc = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  smb_alert_responder i_smb_alert_responder (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_q), .sda_i(sda_bus),
    .fault_evt_i(fault), .dev_addr_i(DEV),
    .sda_drive_low_o(sda_drv), .alert_drive_o(alert), .irq_pending_o(pend)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sda_drv) drive_cnt <= drive_cnt + 1;
    if (cyc == 150000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic half_wait(); repeat (HALF) @(negedge clk); endtask

  task automatic bus_start();
    host_sda = 1'b1; half_wait();
    scl_q = 1'b1;    half_wait();
    host_sda = 1'b0; half_wait();
    scl_q = 1'b0;
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; rival_rel = 1'b1; half_wait();
    scl_q = 1'b1; half_wait();
    host_sda = 1'b1; half_wait();
  endtask

  task automatic bit_cycle(input logic hb, input logic rb, output logic s, output logic steady);
    host_sda = hb; rival_rel = rb; half_wait();
    scl_q = 1'b1;
    repeat (3) @(negedge clk);
    s = sda_bus;
    repeat (HALF - 3) @(negedge clk);
    steady = (sda_bus == s);
    scl_q = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic rival_ack, output logic acked);
    logic s, st;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b1, s, st);
    bit_cycle(1'b1, ~rival_ack, s, st);
    acked = ~s;
  endtask

  task automatic read_byte(input logic [7:0] rival_b, output logic [7:0] b, output logic all_steady);
    logic s, st;
    all_steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, rival_b[i], s, st);
      b[i] = s;
      all_steady = all_steady & st;
    end
  endtask

  task automatic pulse_fault();
    @(negedge clk) fault = 1'b1;
    @(negedge clk) fault = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 alert", alert, 0);
    check("R2 pending", pend, 0);
    check("R2 sda", sda_drv, 0);
  endtask

  task automatic t_no_irq();
    logic ack; int d0;
    d0 = drive_cnt;
    bus_start(); send_byte(8'h19, 1'b0, ack); bus_stop();
    check("R7 no ack", ack, 0);
    check("R7 no drive", drive_cnt - d0, 0);
  endtask

  task automatic t_fault();
    pulse_fault();
    repeat (40) @(negedge clk);
    check("R1 pending held", pend, 1);
    check("R1 alert held", alert, 1);
  endtask

  task automatic t_wrong_addr();
    logic ack; int d0;
    d0 = drive_cnt;
    bus_start(); send_byte(8'h18, 1'b0, ack); bus_stop();
    check("R8 write no ack", ack, 0);
    bus_start(); send_byte(8'h1B, 1'b0, ack); bus_stop();
    check("R8 other read no ack", ack, 0);
    check("R8 no drive", drive_cnt - d0, 0);
    check("R8 latch kept", pend, 1);
  endtask

  task automatic t_abort_then_serve();
    logic ack, s, st, stdy; logic [7:0] b; int d0;
    d0 = drive_cnt;
    bus_start();
    for (int i = 7; i >= 4; i--) bit_cycle(logic'(8'h19 >> i), 1'b1, s, st);
    bus_stop();
    check("R10 stop abort latch", pend, 1);
    check("R10 stop abort no drive", drive_cnt - d0, 0);
    bus_start();
    for (int i = 7; i >= 5; i--) bit_cycle(logic'(8'h19 >> i), 1'b1, s, st);
    bus_start();
    send_byte(8'h19, 1'b0, ack);
    check("R10 restart ack", ack, 1);
    check("R3 ack", ack, 1);
    read_byte(8'hFF, b, stdy);
    check("R4 byte", b, {DEV, 1'b1});
    check("R4 steady", stdy, 1);
    bit_cycle(1'b1, 1'b1, s, st);   // host NACK
    bus_stop();
    check("R5 nack clears pending", pend, 0);
    check("R5 alert released", alert, 0);
  endtask

  task automatic t_arbitration();
    logic ack, s, st, stdy; logic [7:0] b;
    pulse_fault();
    bus_start(); send_byte(8'h19, 1'b1, ack);
    read_byte({RIVAL, 1'b1}, b, stdy);
    bit_cycle(1'b1, 1'b1, s, st);
    bus_stop();
    check("R6 bus carries rival", b, {RIVAL, 1'b1});
    check("R6 loser keeps latch", pend, 1);
    bus_start(); send_byte(8'h19, 1'b0, ack);
    check("R3 ack after loss", ack, 1);
    read_byte(8'hFF, b, stdy);
    bit_cycle(1'b0, 1'b1, s, st);   // host ACK
    bus_stop();
    check("R4 byte alone", b, {DEV, 1'b1});
    check("R5 ack clears", pend, 0);
  endtask

  task automatic t_fault_on_clear();
    logic ack, s, st, stdy; logic [7:0] b;
    pulse_fault();
    bus_start(); send_byte(8'h19, 1'b0, ack);
    read_byte(8'hFF, b, stdy);
    fault = 1'b1;
    bit_cycle(1'b0, 1'b1, s, st);
    bus_stop();
    fault = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 set wins", pend, 1);
    bus_start(); send_byte(8'h19, 1'b0, ack);
    read_byte(8'hFF, b, stdy);
    bit_cycle(1'b1, 1'b1, s, st);
    bus_stop();
    check("R9 later service clears", pend, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_no_irq();
    t_fault();
    t_wrong_addr();
    t_abort_then_serve();
    t_arbitration();
    t_fault_on_clear();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule